// File: doc/BRIEF.md
# Per-Processor Masked Interrupt Router

The router gathers up to 64 level-sensitive device interrupt lines into one raw request vector and distributes that vector to four processors. Each processor owns a private mask register; the processor's interrupt line rises whenever at least one raw request it has unmasked is pending, and falls as soon as none is. A separate legacy interrupt controller output is merged into raw bit 55.

Software reaches the masks, the raw vector and each processor's masked view through a 32-bit register port. Every register is 64 bits wide, so an access is split into two halves that share a single 32-bit holding latch: a write of the lower half only parks data in the latch, and the upper-half write commits both halves at once; a lower-half read returns the low word and parks the high word in the latch for the following upper-half read. The bench and any master are expected not to assert read and write strobes in the same cycle; if they do, the write is performed and the read is dropped.

Top module: `intr_router`

## Requirements
- R1: Raw request bit n equals device input n as sampled two rising clock edges earlier (two-flop synchroniser); raw bit 55 is the OR of device input 55 and the legacy interrupt input.
- R2: `cpuIrq[i]` is high exactly when (mask i AND raw) is nonzero, and follows a mask commit or raw change in the same cycle that register updates.
- R3: A write with address bit 2 clear only loads the 32-bit holding latch and changes no register; a write with address bit 2 set commits {write data, latch} (write data as bits 63:32) to the register at the address with bit 2 cleared.
- R4: A read with address bit 2 clear returns bits 31:0 on `regRdData` one cycle later and loads bits 63:32 into the shared latch; a read with bit 2 set returns the latch one cycle later, whatever the address.
- R5: Register offsets: masks of processors 0..3 at 0x200, 0x240, 0x600, 0x640; masked requests of processors 0..3 at 0x280, 0x2C0, 0x680, 0x6C0; raw request at 0x300. A masked request reads as mask AND raw.
- R6: The raw and masked request registers are read-only; committing a write to their offsets changes no state.
- R7: Committing a mask write changes only the mask of the addressed processor.
- R8: A lower-half read of an unmapped offset returns 0xFFFFFFFF and leaves the latch unchanged; a committed write to an unmapped offset changes nothing.
- R9: Reset clears masks, raw vector, synchroniser, latch and read data, so all interrupt outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| devIrq | input | NUM_LINES | Asynchronous level device requests |
| legacyIrq | input | 1 | Legacy controller request, merged into raw bit 55 |
| regAddr | input | 12 | Register byte address; bit 2 selects the upper half |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regWrData | input | 32 | Write data half |
| regRdData | output | 32 | Read data half, valid the cycle after the strobe |
| cpuIrq | output | 4 | Per-processor interrupt lines |

## Verification
Random device vectors against random masks exercise the AND-reduce for each processor and separate a wrong mask from a wrong raw bit, since the bench also reads every masked view back. Directed patterns isolate the legacy line alone on bit 55, a parked lower half followed by an upper half to another register (proving the latch is shared), a read of one register's high half after another's low half, and unmapped offsets. A mask committed while raw is already set checks that the interrupt line moves in the same cycle as the commit, and writes aimed at the read-only offsets confirm no mask moves.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;
  localparam int NUM_CPUS = 4;
  localparam int CPU_W = $clog2(NUM_CPUS);
  localparam int ADDR_W = 12;
  localparam int HALF_W = 32;
  localparam int REG_W = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] OFS_RAW = ADDR_W'(32'h300);

  // Mask offsets form two pairs; the masked view sits 0x80 above each mask.
  function automatic logic [ADDR_W-1:0] maskOfs(input int unsigned idx);
    if (idx < 2) return ADDR_W'(32'h200 + idx * 32'h40);
    else return ADDR_W'(32'h600 + (idx - 2) * 32'h40);
  endfunction

  function automatic logic [ADDR_W-1:0] maskedOfs(input int unsigned idx);
    return maskOfs(idx) + ADDR_W'(32'h80);
  endfunction

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_MASK,
    SRC_MASKED,
    SRC_RAW
  } rdSrc_e;

  typedef struct packed {
    logic                latchLoad;
    logic [NUM_CPUS-1:0] maskLoad;
    logic                rdLow;
    logic                rdHigh;
    rdSrc_e              rdSrc;
    logic [CPU_W-1:0]    rdCpu;
  } ctrlStrobe_t;
endpackage

// File: rtl/intr_router_ctrl.sv
module intr_router_ctrl
  import intr_router_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       strobe
);
  logic [ADDR_W-1:0] baseAddr;
  logic upperHalf;

  assign upperHalf = addr[2];
  assign baseAddr = addr & ~ADDR_W'(4);

  always_comb begin
    strobe = '0;
    strobe.rdSrc = SRC_NONE;
    if (wrEn) begin
      if (!upperHalf) begin
        strobe.latchLoad = 1'b1;
      end else begin
        for (int i = 0; i < NUM_CPUS; i++) begin
          if (baseAddr == maskOfs(i)) strobe.maskLoad[i] = 1'b1;
        end
      end
    end else if (rdEn) begin
      strobe.rdLow = !upperHalf;
      strobe.rdHigh = upperHalf;
      if (baseAddr == OFS_RAW) strobe.rdSrc = SRC_RAW;
      for (int i = 0; i < NUM_CPUS; i++) begin
        if (baseAddr == maskOfs(i)) begin
          strobe.rdSrc = SRC_MASK;
          strobe.rdCpu = CPU_W'(i);
        end
        if (baseAddr == maskedOfs(i)) begin
          strobe.rdSrc = SRC_MASKED;
          strobe.rdCpu = CPU_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/intr_router_datapath.sv
module intr_router_datapath
  import intr_router_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int LEGACY_BIT = 55
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_LINES-1:0]          devIrq,
  input  logic                          legacyIrq,
  input  logic [HALF_W-1:0]             wrData,
  input  ctrlStrobe_t                   strobe,
  output logic [HALF_W-1:0]             rdData,
  output logic [NUM_CPUS-1:0]           cpuIrq,
  output logic [NUM_LINES-1:0]          rawReq,
  output logic [NUM_CPUS*NUM_LINES-1:0] maskFlat
);
  localparam logic [NUM_LINES-1:0] LEGACY_VEC = NUM_LINES'(1) << LEGACY_BIT;

  logic [NUM_LINES-1:0] lineIn;
  logic [NUM_LINES-1:0] syncStage;
  logic [HALF_W-1:0]    halfLatch;
  logic [REG_W-1:0]     commitVal;
  logic [REG_W-1:0]     selVal;
  logic [NUM_LINES-1:0] maskReg [NUM_CPUS];

  assign lineIn = devIrq | (legacyIrq ? LEGACY_VEC : '0);
  assign commitVal = {wrData, halfLatch};

  always_ff @(posedge clk) begin
    if (rst) begin
      syncStage <= '0;
      rawReq <= '0;
    end else begin
      syncStage <= lineIn;
      rawReq <= syncStage;
    end
  end

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) maskReg[g] <= '0;
      else if (strobe.maskLoad[g]) maskReg[g] <= commitVal[NUM_LINES-1:0];
    end
    assign cpuIrq[g] = |(maskReg[g] & rawReq);
    assign maskFlat[g*NUM_LINES +: NUM_LINES] = maskReg[g];
  end

  always_comb begin
    unique case (strobe.rdSrc)
      SRC_MASK:   selVal = REG_W'(maskReg[strobe.rdCpu]);
      SRC_MASKED: selVal = REG_W'(maskReg[strobe.rdCpu] & rawReq);
      SRC_RAW:    selVal = REG_W'(rawReq);
      default:    selVal = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halfLatch <= '0;
      rdData <= '0;
    end else begin
      if (strobe.latchLoad) halfLatch <= wrData;
      if (strobe.rdLow) begin
        rdData <= selVal[HALF_W-1:0];
        if (strobe.rdSrc != SRC_NONE) halfLatch <= selVal[REG_W-1:HALF_W];
      end
      if (strobe.rdHigh) rdData <= halfLatch;
    end
  end
endmodule

// File: rtl/intr_router.sv
module intr_router
  import intr_router_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int LEGACY_BIT = 55
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] devIrq,
  input  logic                 legacyIrq,
  input  logic [11:0]          regAddr,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic [3:0]           cpuIrq
);
  ctrlStrobe_t strobe;
  logic [NUM_LINES-1:0] rawReq;
  logic [NUM_CPUS*NUM_LINES-1:0] maskFlat;

  intr_router_ctrl u_ctrl (
    .wrEn  (regWrEn),
    .rdEn  (regRdEn),
    .addr  (regAddr),
    .strobe(strobe)
  );

  intr_router_datapath #(
    .NUM_LINES (NUM_LINES),
    .LEGACY_BIT(LEGACY_BIT)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .devIrq   (devIrq),
    .legacyIrq(legacyIrq),
    .wrData   (regWrData),
    .strobe   (strobe),
    .rdData   (regRdData),
    .cpuIrq   (cpuIrq),
    .rawReq   (rawReq),
    .maskFlat (maskFlat)
  );
endmodule

// File: rtl/intr_router_checker.sv
module intr_router_checker
  import intr_router_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int LEGACY_BIT = 55
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_LINES-1:0]          devIrq,
  input logic                          legacyIrq,
  input logic [11:0]                   regAddr,
  input logic                          regWrEn,
  input logic [31:0]                   regRdData,
  input logic [3:0]                    cpuIrq,
  input logic [NUM_LINES-1:0]          rawReq,
  input logic [NUM_CPUS*NUM_LINES-1:0] maskFlat
);
  localparam logic [NUM_LINES-1:0] LEG_VEC = NUM_LINES'(1) << LEGACY_BIT;
  logic [1:0] upCnt;
  logic [NUM_LINES-1:0] seenLines;
  logic [11:0] chkBase;

  assign seenLines = devIrq | ({NUM_LINES{legacyIrq}} & LEG_VEC);
  assign chkBase = regAddr & ~12'd4;

  always_ff @(posedge clk) begin
    if (rst) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assert_raw_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (upCnt >= 2'd2) |-> (rawReq == $past(seenLines, 2)));

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpuIrq == 4'd0 && regRdData == 32'd0));

  assert_low_write_only_latch_R3: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && !regAddr[2]) |=> $stable(maskFlat));

  assert_readonly_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr[2] && (chkBase == OFS_RAW || chkBase == maskedOfs(0) ||
     chkBase == maskedOfs(1) || chkBase == maskedOfs(2) || chkBase == maskedOfs(3)))
    |=> $stable(maskFlat));

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_chk
    assert_other_mask_kept_R7: assert property (@(posedge clk) disable iff (rst)
      (regWrEn && regAddr[2] && chkBase != maskOfs(g))
      |=> $stable(maskFlat[g*NUM_LINES +: NUM_LINES]));

    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      (maskFlat[g*NUM_LINES +: NUM_LINES] == '0) |-> !cpuIrq[g]);
  end
endmodule

bind intr_router intr_router_checker #(
  .NUM_LINES (NUM_LINES),
  .LEGACY_BIT(LEGACY_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .devIrq   (devIrq),
  .legacyIrq(legacyIrq),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regRdData(regRdData),
  .cpuIrq   (cpuIrq),
  .rawReq   (rawReq),
  .maskFlat (maskFlat)
);

// File: tb/sim_intr_router.sv
`timescale 1ns/1ps
module sim_intr_router;
  logic        clk = 0;
  logic        rst = 1;
  logic [63:0] devIrq = '0;
  logic        legacyIrq = 0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 0;
  logic        regRdEn = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  cpuIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] expMask [4];
  logic [63:0] expRaw = '0;

  always #10 clk = ~clk;

  intr_router u0 (
    .clk(clk), .rst(rst), .devIrq(devIrq), .legacyIrq(legacyIrq),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .cpuIrq(cpuIrq)
  );

  // R5 offsets as the bench sees them
  function automatic logic [11:0] ofsMask(int i);
    return (i < 2) ? 12'(12'h200 + i * 12'h40) : 12'(12'h600 + (i - 2) * 12'h40);
  endfunction
  function automatic logic [11:0] ofsMasked(int i);
    return ofsMask(i) + 12'h80;
  endfunction
  function automatic logic [3:0] expIrq();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = |(expMask[i] & expRaw);
    return v;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write64(logic [11:0] base, logic [63:0] val);
    @(negedge clk);
    regAddr = base; regWrEn = 1; regWrData = val[31:0];
    @(negedge clk);
    regAddr = base | 12'd4; regWrData = val[63:32];
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic read64(logic [11:0] base, output logic [63:0] val);
    @(negedge clk);
    regAddr = base; regRdEn = 1;
    @(negedge clk);
    val[31:0] = regRdData;
    regAddr = base | 12'd4;
    @(negedge clk);
    val[63:32] = regRdData;
    regRdEn = 0;
  endtask

  task automatic setLines(logic [63:0] dv, logic leg);
    @(negedge clk);
    devIrq = dv; legacyIrq = leg;
    expRaw = dv | (leg ? (64'd1 << 55) : 64'd0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [63:0] rv, a, b;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4; i++) expMask[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 irq after reset", 64'(cpuIrq), 64'd0);
    chk("R9 rdData after reset", 64'(regRdData), 64'd0);
    for (int i = 0; i < 4; i++) begin
      read64(ofsMask(i), rv);
      chk("R9 mask cleared", rv, 64'd0);
    end
    read64(12'h300, rv);
    chk("R9 raw cleared", rv, 64'd0);

    // R5 / R3 / R4: distinct masks read back
    for (int i = 0; i < 4; i++) begin
      expMask[i] = {$urandom(), $urandom()};
      write64(ofsMask(i), expMask[i]);
    end
    for (int i = 0; i < 4; i++) begin
      read64(ofsMask(i), rv);
      chk("R5 mask readback", rv, expMask[i]);
    end
    // R7: rewrite one mask, others hold
    expMask[2] = 64'hA5A5_0F0F_3C3C_9999;
    write64(ofsMask(2), expMask[2]);
    for (int i = 0; i < 4; i++) begin
      read64(ofsMask(i), rv);
      chk("R7 masks after single write", rv, expMask[i]);
    end

    // R1 / R2 / R5 masked views
    setLines({$urandom(), $urandom()}, 0);
    chk("R2 irq vector", 64'(cpuIrq), 64'(expIrq()));
    read64(12'h300, rv);
    chk("R1 raw follows lines", rv, expRaw);
    for (int i = 0; i < 4; i++) begin
      read64(ofsMasked(i), rv);
      chk("R5 masked view", rv, expMask[i] & expRaw);
    end

    // R1 legacy line alone
    setLines(64'd0, 1);
    read64(12'h300, rv);
    chk("R1 legacy on bit 55", rv, 64'd1 << 55);
    chk("R2 irq with legacy", 64'(cpuIrq), 64'(expIrq()));

    // R6: writes to read-only offsets
    write64(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
    write64(ofsMasked(0), 64'h1234_5678_9ABC_DEF0);
    write64(ofsMasked(3), 64'h0);
    for (int i = 0; i < 4; i++) begin
      read64(ofsMask(i), rv);
      chk("R6 masks unchanged", rv, expMask[i]);
    end
    read64(12'h300, rv);
    chk("R6 raw unchanged", rv, expRaw);

    // R3: parked lower half, committed by upper half of another register
    a = 64'(32'hCAFE_0001); b = 64'(32'h0BAD_F00D);
    @(negedge clk); regAddr = ofsMask(0); regWrEn = 1; regWrData = a[31:0];
    @(negedge clk); regWrEn = 0;
    read64(ofsMask(0), rv);
    chk("R3 low write alone no effect", rv, expMask[0]);
    @(negedge clk); regAddr = ofsMask(1); regWrEn = 1; regWrData = a[31:0];
    @(negedge clk); regAddr = ofsMask(3) | 12'd4; regWrData = b[31:0];
    @(negedge clk); regWrEn = 0;
    expMask[3] = {b[31:0], a[31:0]};
    read64(ofsMask(3), rv);
    chk("R3 shared latch commit", rv, expMask[3]);
    read64(ofsMask(1), rv);
    chk("R3 parked target untouched", rv, expMask[1]);

    // R4: high half of another register returns latch
    @(negedge clk); regAddr = ofsMask(2); regRdEn = 1;
    @(negedge clk); chk("R4 low half", 64'(regRdData), 64'(expMask[2][31:0]));
    regAddr = ofsMask(0) | 12'd4;
    @(negedge clk); chk("R4 high from latch", 64'(regRdData), 64'(expMask[2][63:32]));
    regRdEn = 0;

    // R8: unmapped read and write
    read64(ofsMask(1), rv);
    @(negedge clk); regAddr = 12'h010; regRdEn = 1;
    @(negedge clk); chk("R8 unmapped reads ones", 64'(regRdData), 64'hFFFF_FFFF);
    regAddr = 12'h014;
    @(negedge clk); chk("R8 latch kept", 64'(regRdData), 64'(expMask[1][63:32]));
    regRdEn = 0;
    write64(12'h100, 64'h5555_AAAA_5555_AAAA);
    for (int i = 0; i < 4; i++) begin
      read64(ofsMask(i), rv);
      chk("R8 unmapped write ignored", rv, expMask[i]);
    end

    // R2 timing: commit of mask moves irq in the same cycle
    expMask[0] = '0;
    write64(ofsMask(0), 64'd0);
    setLines(64'h0000_0100_0000_0000, 0);
    chk("R2 irq0 low with zero mask", 64'(cpuIrq[0]), 64'd0);
    @(negedge clk); regAddr = ofsMask(0); regWrEn = 1; regWrData = 32'd0;
    @(negedge clk); regAddr = ofsMask(0) | 12'd4; regWrData = 32'h0000_0100;
    @(negedge clk); regWrEn = 0;
    expMask[0] = 64'h0000_0100_0000_0000;
    chk("R2 irq0 rises on commit", 64'(cpuIrq[0]), 64'd1);
    setLines(64'd0, 0);
    chk("R2 irq drops with raw", 64'(cpuIrq), 64'd0);

    // Random mix
    for (int n = 0; n < 150; n++) begin
      int c;
      c = $urandom_range(3);
      expMask[c] = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      write64(ofsMask(c), expMask[c]);
      setLines({$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()},
               1'($urandom_range(1)));
      chk("R2 random irq", 64'(cpuIrq), 64'(expIrq()));
      c = $urandom_range(3);
      read64(ofsMasked(c), rv);
      chk("R5 random masked", rv, expMask[c] & expRaw);
    end
    finish();
  end
endmodule